// File: doc/BRIEF.md
# Keyboard and Console Interrupt Mailbox

This block is a small memory-mapped I/O slave on a single-cycle word bus. It joins a processor to two character streams: an input stream from a keyboard device and an output stream to a display device. Each stream passes through a one-character mailbox, and each mailbox has its own fixed interrupt level. The block drives a 4-bit interrupt request level to the processor.

The two mailboxes work in opposite directions. On the keyboard side, the device fills the slot and raises an interrupt. The processor then empties the slot by reading it. On the console side, the processor fills the slot. The device drains it, and only after that does the block raise an interrupt. Three control words sit beside the mailboxes:

- a readable copy of the current request level;
- a write-only request that pulses a processor reset line for one cycle;
- a sticky, read-only error flag that the processor's error output sets.

Bus reads are combinational. A read or write takes effect at the rising edge on which `bus_sel` is high.

Top module: `periph_mailbox`

## Requirements
- R1: After reset the block shows the following: `irl` is 0, `kb_ready` is 1, `con_valid` is 0, `cpu_reset` is 0, and the error word reads 0.
- R2: A keyboard character is accepted at an edge where `kb_valid` and `kb_ready` are both high. From the next cycle the slot is full, `kb_ready` is 0 and `irl` is 10.
- R3: While the keyboard slot is full, `kb_ready` stays 0 and an offered character is held off, not dropped. After the processor reads the slot, `kb_ready` returns to 1 and the held character is accepted.
- R4: A read of address 0x6000 returns the keyboard character in bits 7:0 and the full flag in bit 8. The read empties the slot and withdraws the keyboard interrupt.
- R5: A write to 0x3000 while the console slot is empty loads bits 7:0. The block then asserts `con_valid` with that character until `con_ready` is seen. A write while the slot is still full is ignored.
- R6: When the device takes a console character, `irl` becomes 11. That interrupt clears on the next write to 0x3000 or on a read of the console status word at 0x3004. The status word has bit 0 = slot full and bit 1 = done interrupt pending.
- R7: When both interrupts are pending, `irl` shows the higher level, 11. When only one is pending, `irl` shows that interrupt's level.
- R8: A read of 0x37D4 returns the current request level in bits 3:0.
- R9: A write to 0x37D8 with bit 0 set drives `cpu_reset` high for exactly the one cycle after the write edge. A write with bit 0 clear produces no pulse.
- R10: When `cpu_error` is high at an edge, bit 0 of the word at 0x37DC becomes 1 and stays 1 until reset. Bus writes to 0x37DC do not change it.
- R11: A read of an address with no register behind it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| kb_valid | input | 1 | Keyboard character offered |
| kb_data | input | 8 | Keyboard character |
| kb_ready | output | 1 | Keyboard slot can take a character |
| con_valid | output | 1 | Console character waiting |
| con_data | output | 8 | Console character |
| con_ready | input | 1 | Display device takes the character |
| cpu_error | input | 1 | Processor error indication |
| cpu_reset | output | 1 | One-cycle reset request to the processor |
| irl | output | 4 | Interrupt request level, 0 = none |

## Verification
A slot flag stuck full or stuck empty shows up at the ports in the next cycle: `kb_ready` or `con_valid` takes the wrong value, or a character is lost or duplicated in the console scoreboard. A pending bit that fails to clear, or that is wrongly cleared, shows in `irl` one cycle after the bus access that should have changed it. The bench checks `irl` after each such access, so these faults surface at once. A mix-up between the two levels appears as soon as both interrupts are pending.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int IRL_W = 4;

  typedef enum logic [2:0] {
    RG_NONE, RG_CON_DATA, RG_CON_STAT, RG_KB_DATA, RG_IRL, RG_RST, RG_ERR
  } mbx_reg_e;

  // Higher of the pending levels; 0 when nothing is pending
  function automatic logic [IRL_W-1:0] mbx_level(
      input logic kb_p, input logic con_p,
      input logic [IRL_W-1:0] kb_lvl, input logic [IRL_W-1:0] con_lvl);
    logic [IRL_W-1:0] a;
    logic [IRL_W-1:0] b;
    a = kb_p  ? kb_lvl  : '0;
    b = con_p ? con_lvl : '0;
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int unsigned CON_BASE = 'h3000,
  parameter int unsigned KB_BASE  = 'h6000,
  parameter int unsigned CTL_BASE = 'h37D4
) (
  input  logic [ADDR_W-1:0] addr,
  output mbx_reg_e          region
);
  always_comb begin
    if      (addr == ADDR_W'(CON_BASE))     region = RG_CON_DATA;
    else if (addr == ADDR_W'(CON_BASE + 4)) region = RG_CON_STAT;
    else if (addr == ADDR_W'(KB_BASE))      region = RG_KB_DATA;
    else if (addr == ADDR_W'(CTL_BASE))     region = RG_IRL;
    else if (addr == ADDR_W'(CTL_BASE + 4)) region = RG_RST;
    else if (addr == ADDR_W'(CTL_BASE + 8)) region = RG_ERR;
    else                                    region = RG_NONE;
  end
endmodule

// File: rtl/mbx_kb_slot.sv
module mbx_kb_slot #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              full,
  output logic [CHAR_W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  assign in_ready = !full;
endmodule

// File: rtl/mbx_con_slot.sv
module mbx_con_slot #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CHAR_W-1:0] wdata,
  input  logic              stat_rd,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  input  logic              out_ready,
  output logic              done
);
  logic drained;
  assign drained = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (drained) begin
      out_valid <= 1'b0;
    end else if (wr && !out_valid) begin
      out_valid <= 1'b1;
      out_data  <= wdata;
    end
  end

  // A new drain event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)              done <= 1'b0;
    else if (drained)        done <= 1'b1;
    else if (wr || stat_rd)  done <= 1'b0;
  end
endmodule

// File: rtl/periph_mailbox.sv
module periph_mailbox
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8,
  parameter int unsigned CON_BASE = 'h3000,
  parameter int unsigned KB_BASE  = 'h6000,
  parameter int unsigned CTL_BASE = 'h37D4,
  parameter int unsigned KB_LEVEL  = 10,
  parameter int unsigned CON_LEVEL = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kb_valid,
  input  logic [CHAR_W-1:0] kb_data,
  output logic              kb_ready,
  output logic              con_valid,
  output logic [CHAR_W-1:0] con_data,
  input  logic              con_ready,
  input  logic              cpu_error,
  output logic              cpu_reset,
  output logic [3:0]        irl
);
  localparam logic [IRL_W-1:0] KB_LVL  = IRL_W'(KB_LEVEL);
  localparam logic [IRL_W-1:0] CON_LVL = IRL_W'(CON_LEVEL);

  mbx_reg_e region;
  logic     rd_ev, wr_ev;
  logic     kb_pend, con_pend, con_full;
  logic [CHAR_W-1:0] kb_char;
  logic     err_q, rst_q;
  logic     unused_wbits;

  assign rd_ev = bus_sel && !bus_we;
  assign wr_ev = bus_sel && bus_we;
  assign unused_wbits = ^bus_wdata[DATA_W-1:CHAR_W];

  mbx_decode #(.ADDR_W(ADDR_W), .CON_BASE(CON_BASE), .KB_BASE(KB_BASE),
               .CTL_BASE(CTL_BASE)) u_dec (
    .addr(bus_addr), .region(region));

  mbx_kb_slot #(.CHAR_W(CHAR_W)) u_kb (
    .clk(clk), .rst_n(rst_n),
    .in_valid(kb_valid), .in_data(kb_data), .in_ready(kb_ready),
    .take(rd_ev && region == RG_KB_DATA),
    .full(kb_pend), .data(kb_char));

  mbx_con_slot #(.CHAR_W(CHAR_W)) u_con (
    .clk(clk), .rst_n(rst_n),
    .wr(wr_ev && region == RG_CON_DATA), .wdata(bus_wdata[CHAR_W-1:0]),
    .stat_rd(rd_ev && region == RG_CON_STAT),
    .out_valid(con_full), .out_data(con_data), .out_ready(con_ready),
    .done(con_pend));

  assign con_valid = con_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      err_q <= err_q | cpu_error;
      rst_q <= wr_ev && region == RG_RST && bus_wdata[0];
    end
  end

  assign cpu_reset = rst_q;
  assign irl = mbx_level(kb_pend, con_pend, KB_LVL, CON_LVL);

  always_comb begin
    unique case (region)
      RG_CON_STAT: bus_rdata = DATA_W'({con_pend, con_full});
      RG_KB_DATA:  bus_rdata = DATA_W'({kb_pend, kb_char});
      RG_IRL:      bus_rdata = DATA_W'(irl);
      RG_ERR:      bus_rdata = DATA_W'(err_q);
      default:     bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       kb_valid,
  input logic       kb_ready,
  input logic       con_valid,
  input logic [7:0] con_data,
  input logic       con_ready,
  input logic       cpu_reset,
  input logic       kb_pend,
  input logic       con_pend,
  input logic       err_q,
  input logic [3:0] irl
);
  // R2
  kb_full_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_valid && kb_ready) |=> (!kb_ready && irl != 4'd0));
  // R5
  con_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (con_valid && !con_ready) |=> (con_valid && $stable(con_data)));
  // R7
  prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kb_pend && con_pend) |-> (irl == 4'd11));
  // R9
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_reset |=> !cpu_reset);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  // R6
  con_done_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (con_valid && con_ready) |=> (irl == 4'd11));
endmodule

bind periph_mailbox mbx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .kb_valid(kb_valid), .kb_ready(kb_ready),
  .con_valid(con_valid), .con_data(con_data), .con_ready(con_ready),
  .cpu_reset(cpu_reset), .kb_pend(kb_pend), .con_pend(con_pend),
  .err_q(err_q), .irl(irl));

// File: tb/periph_mailbox_tb.sv
`timescale 1ns/1ps
module periph_mailbox_tb;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0;
  logic [15:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic kb_valid = 0; logic [7:0] kb_data = 0; logic kb_ready;
  logic con_valid; logic [7:0] con_data; logic con_ready = 0;
  logic cpu_error = 0, cpu_reset; logic [3:0] irl;

  int tests = 0, fails = 0;
  logic [7:0] con_q[$];
  logic [31:0] rd;

  always #4 clk = ~clk;

  periph_mailbox u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_sel = 0;
  endtask

  // driver: console write pushes expected item when the slot is free
  task automatic con_send(input logic [7:0] c);
    if (!con_valid) con_q.push_back(c);
    bus_write(16'h3000, {24'h0, c});
  endtask

  task automatic con_take();
    @(negedge clk); con_ready = 1;
    @(posedge clk); #1 con_ready = 0;
  endtask

  task automatic kb_push(input logic [7:0] c);
    @(negedge clk); kb_valid = 1; kb_data = c;
    @(posedge clk); #1 kb_valid = 0;
  endtask

  // monitor: compare each console handshake with the scoreboard
  always @(negedge clk) begin
    #2;
    if (con_valid && con_ready) begin
      if (con_q.size() == 0) chk("R5 unexpected console char", {24'h0, con_data}, 32'hFFFF_FFFF);
      else chk("R5 console char", {24'h0, con_data}, {24'h0, con_q.pop_front()});
    end
  end

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    // R1
    chk("R1 irl", irl, 0); chk("R1 kb_ready", kb_ready, 1);
    chk("R1 con_valid", con_valid, 0); chk("R1 cpu_reset", cpu_reset, 0);
    bus_read(16'h37DC, rd); chk("R1 err", rd, 0);

    // R2 keyboard accept
    kb_push(8'h41);
    chk("R2 kb_ready", kb_ready, 0); chk("R2 irl", irl, 10);

    // R3 hold-off: offer a second char while full
    @(negedge clk); kb_valid = 1; kb_data = 8'h42;
    repeat (3) @(posedge clk);
    #1 chk("R3 held ready", kb_ready, 0);
    bus_read(16'h6000, rd); chk("R4 kb read", rd, 32'h141);
    chk("R3 ready back", kb_ready, 1);
    @(posedge clk); #1 kb_valid = 0;
    chk("R3 taken", kb_ready, 0); chk("R3 irl", irl, 10);
    bus_read(16'h6000, rd); chk("R3 held char kept", rd, 32'h142);
    chk("R4 irl cleared", irl, 0); chk("R4 ready", kb_ready, 1);

    // R5 console write and ignored overwrite
    con_send(8'h55);
    chk("R5 valid", con_valid, 1); chk("R5 data", con_data, 8'h55);
    con_send(8'h66);
    chk("R5 ignored", con_data, 8'h55);
    con_take();
    chk("R6 irl", irl, 11); chk("R6 valid drop", con_valid, 0);
    bus_read(16'h3004, rd); chk("R6 status", rd, 2);
    chk("R6 cleared by status", irl, 0);

    // R7 priority, R8 level register
    kb_push(8'h30); chk("R7 kb only", irl, 10);
    con_send(8'h77); con_take(); chk("R7 both", irl, 11);
    bus_read(16'h37D4, rd); chk("R8 level 11", rd, 11);
    con_send(8'h78); chk("R6 cleared by write", irl, 10);
    bus_read(16'h37D4, rd); chk("R8 level 10", rd, 10);
    con_take(); chk("R7 both again", irl, 11);
    bus_read(16'h3004, rd); chk("R7 back to kb", irl, 10);
    bus_read(16'h6000, rd); chk("R4 kb read2", rd, 32'h130);
    chk("R7 none", irl, 0);

    // R9 reset pulse
    bus_write(16'h37D8, 1); chk("R9 pulse", cpu_reset, 1);
    @(posedge clk); #1 chk("R9 one cycle", cpu_reset, 0);
    bus_write(16'h37D8, 0); chk("R9 no pulse", cpu_reset, 0);

    // R10 sticky error
    @(negedge clk); cpu_error = 1; @(negedge clk); cpu_error = 0;
    bus_read(16'h37DC, rd); chk("R10 set", rd, 1);
    bus_write(16'h37DC, 0);
    bus_read(16'h37DC, rd); chk("R10 write ignored", rd, 1);

    // R11 unmapped
    bus_read(16'h1234, rd); chk("R11 unmapped", rd, 0);

    chk("R5 scoreboard empty", con_q.size(), 0);
    repeat (2) @(posedge clk);
    finish_up();
  end
endmodule